// File: doc/BRIEF.md
# Dual-clock FIFO with handshake flags

This block carries data words from a producer running on one clock to a consumer running on an unrelated clock. Words are held in a small register array. Each side keeps a binary pointer that is one bit wider than the address. The pointers cross to the other domain as Gray code through two-flop synchronizers. The read side works out empty from its own pointer and a synchronized copy of the write pointer. The write side works out full from its own pointer and a synchronized copy of the read pointer.

Each request also gets a registered answer one clock later in its own domain. An accepted write raises an acknowledge and a refused write raises an overflow flag. An accepted read raises a valid flag and a read made while empty raises an underflow flag. A parameter sets each of these four flags to active high or active low. The write side also reports how many words the FIFO holds as it sees them. That figure can run high while a read has not yet crossed over.

Top module: `xfer_fifo`

## Requirements
- R1: After both resets, rdEmpty is 1 and wrFull is 0. wrCount is 0 and all four handshake flags are at their inactive level.
- R2: Words come out on rdData in the same order they were accepted on wrData.
- R3: wrFull becomes 1 right after the write edge that leaves DEPTH words held, and wrCount then reads DEPTH. A write request made while full leaves memory, pointer and count unchanged, and its word is never read.
- R4: wrAck is active in the write-clock cycle that follows an accepted write request, for exactly that one cycle. wrOvf stays inactive in that cycle.
- R5: rdValid is active in the read-clock cycle that follows an accepted read request, and rdData then holds the word that was read.
- R6: A read request made while empty makes rdUnder active in the next read-clock cycle. rdValid stays inactive and rdData keeps its value. The read pointer does not move, so the next word written is the next word read.
- R7: rdEmpty becomes 1 right after the read edge that takes the last word. rdEmpty becomes 0 within a few read-clock cycles after a write into an empty FIFO.
- R8: wrCount equals the words written minus the reads seen through the synchronizer. It never exceeds DEPTH, and it returns to 0 a few write cycles after the FIFO is drained.
- R9: A polarity parameter set to 0 (ACK_HI, OVF_HI, VALID_HI, UNDER_HI) inverts its flag, so the inactive level is 1 and the active level is 0. Set to 1, the inactive level is 0.
- R10: wrOvf is active in the write-clock cycle that follows a write request made while full. wrAck stays inactive in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| wrRstN | input | 1 | Write-side asynchronous reset, active low |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to write |
| wrFull | output | 1 | FIFO full, as seen by the write side |
| wrAck | output | 1 | Previous write was accepted (polarity ACK_HI) |
| wrOvf | output | 1 | Previous write was refused (polarity OVF_HI) |
| wrCount | output | $clog2(DEPTH)+1 | Occupancy as seen by the write side |
| rdClk | input | 1 | Read-side clock |
| rdRstN | input | 1 | Read-side asynchronous reset, active low |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Last word read |
| rdEmpty | output | 1 | FIFO empty, as seen by the read side |
| rdValid | output | 1 | Previous read was accepted (polarity VALID_HI) |
| rdUnder | output | 1 | Previous read found the FIFO empty (polarity UNDER_HI) |

## Verification
The assertions assume that DEPTH is a power of two and at least 4. They assume wrEn and rdEn change only synchronously to their own clocks, and that both resets are held together from time zero until the clocks run. The bench holds both resets from the start and releases them together. It changes each request only on a falling edge of its own clock. Before each read that must succeed, it waits enough cycles of both clocks for the pointers to settle through the synchronizers.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
  // Strobes from the control into the storage datapath.
  typedef struct packed {
    logic wrFire;  // write-domain: store wrData at wrAddr
    logic rdFire;  // read-domain: load rdData from rdAddr
  } fifo_strobe_t;
endpackage

// File: rtl/xfer_fifo_sync.sv
module xfer_fifo_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xfer_fifo_ctrl.sv
module xfer_fifo_ctrl
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          wrEn,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic          rdEn,
  output fifo_strobe_t  strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          wrFull,
  output logic          rdEmpty,
  output logic [PW-1:0] wrCount,
  output logic          ackRaw,
  output logic          ovfRaw,
  output logic          validRaw,
  output logic          underRaw
);
  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wBin, wGray, wNext, rGraySync, rBinSync;
  logic          wFire;

  assign wNext  = wBin + 1'b1;
  assign wrFull = (wGray == {~rGraySync[PW-1:PW-2], rGraySync[PW-3:0]});
  assign wFire  = wrEn && !wrFull;
  assign wrAddr = wBin[AW-1:0];
  assign rBinSync = fromGray(rGraySync);
  assign wrCount  = wBin - rBinSync;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wBin   <= '0;
      wGray  <= '0;
      ackRaw <= 1'b0;
      ovfRaw <= 1'b0;
    end else begin
      ackRaw <= wFire;
      ovfRaw <= wrEn && wrFull;
      if (wFire) begin
        wBin  <= wNext;
        wGray <= toGray(wNext);
      end
    end
  end

  a_r3_reject_holds_ptr: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrEn && wrFull) |=> (wBin == $past(wBin)));
  a_r3_full_means_depth: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrFull |-> (wrCount == DEPTH_V));
  a_r8_count_bound: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrCount <= DEPTH_V);
  a_r4_ack_not_ovf: assert property (@(posedge wrClk) disable iff (!wrRstN)
    ackRaw |-> !ovfRaw);

  // ---------------- read domain ----------------
  logic [PW-1:0] rBin, rGray, rNext, wGraySync;
  logic          rFire;

  assign rNext   = rBin + 1'b1;
  assign rdEmpty = (rGray == wGraySync);
  assign rFire   = rdEn && !rdEmpty;
  assign rdAddr  = rBin[AW-1:0];

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rBin     <= '0;
      rGray    <= '0;
      validRaw <= 1'b0;
      underRaw <= 1'b0;
    end else begin
      validRaw <= rFire;
      underRaw <= rdEn && rdEmpty;
      if (rFire) begin
        rBin  <= rNext;
        rGray <= toGray(rNext);
      end
    end
  end

  a_r6_under_holds_ptr: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdEn && rdEmpty) |=> (rBin == $past(rBin)));
  a_r5_valid_not_under: assert property (@(posedge rdClk) disable iff (!rdRstN)
    validRaw |-> !underRaw);

  // ---------------- crossings ----------------
  xfer_fifo_sync #(.W(PW)) u_syncW2R (
    .clk(rdClk), .rstN(rdRstN), .d(wGray), .q(wGraySync)
  );
  xfer_fifo_sync #(.W(PW)) u_syncR2W (
    .clk(wrClk), .rstN(wrRstN), .d(rGray), .q(rGraySync)
  );

  assign strb.wrFire = wFire;
  assign strb.rdFire = rFire;
endmodule

// File: rtl/xfer_fifo_mem.sv
module xfer_fifo_mem
  import xfer_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  fifo_strobe_t      strb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.wrFire) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) rdData <= '0;
    else if (strb.rdFire) rdData <= store[rdAddr];
  end

  a_r6_data_held: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !strb.rdFire |=> (rdData == $past(rdData)));
endmodule

// File: rtl/xfer_fifo.sv
module xfer_fifo
  import xfer_fifo_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 16,
  parameter bit ACK_HI   = 1'b1,
  parameter bit OVF_HI   = 1'b1,
  parameter bit VALID_HI = 1'b1,
  parameter bit UNDER_HI = 1'b1,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  output logic              wrAck,
  output logic              wrOvf,
  output logic [PW-1:0]     wrCount,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty,
  output logic              rdValid,
  output logic              rdUnder
);
  fifo_strobe_t  strb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic          ackRaw, ovfRaw, validRaw, underRaw;

  xfer_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrFull(wrFull), .rdEmpty(rdEmpty), .wrCount(wrCount),
    .ackRaw(ackRaw), .ovfRaw(ovfRaw), .validRaw(validRaw), .underRaw(underRaw)
  );

  xfer_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .wrClk(wrClk), .rdClk(rdClk), .rdRstN(rdRstN), .strb(strb),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  assign wrAck   = ACK_HI   ? ackRaw   : ~ackRaw;
  assign wrOvf   = OVF_HI   ? ovfRaw   : ~ovfRaw;
  assign rdValid = VALID_HI ? validRaw : ~validRaw;
  assign rdUnder = UNDER_HI ? underRaw : ~underRaw;
endmodule

// File: tb/xfer_fifo_bench.sv
module xfer_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD + 4;
  localparam int DEPTH = 16;

  logic wrClk = 0, rdClk = 0, wrRstN = 0, rdRstN = 0, wrEn = 0, rdEn = 0;
  logic [7:0] wrData = '0, rdData, loData;
  logic wrFull, wrAck, wrOvf, rdEmpty, rdValid, rdUnder;
  logic loFull, loAck, loOvf, loEmpty, loValid, loUnder;
  logic [4:0] wrCount, loCount;
  int nChk = 0, nBad = 0;

  always #(CLK_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2) rdClk = ~rdClk;

  xfer_fifo u_xfer_fifo (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData),
    .wrFull(wrFull), .wrAck(wrAck), .wrOvf(wrOvf), .wrCount(wrCount),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData),
    .rdEmpty(rdEmpty), .rdValid(rdValid), .rdUnder(rdUnder)
  );

  xfer_fifo #(.ACK_HI(1'b0), .OVF_HI(1'b0), .VALID_HI(1'b0), .UNDER_HI(1'b0)) u_xfer_fifo_lo (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData),
    .wrFull(loFull), .wrAck(loAck), .wrOvf(loOvf), .wrCount(loCount),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(loData),
    .rdEmpty(loEmpty), .rdValid(loValid), .rdUnder(loUnder)
  );

  // {isWrite, emptyAfter, data}: writes expect wrAck, reads expect rdValid and data
  localparam logic [9:0] VEC [8] = '{
    10'h211, 10'h222, 10'h011, 10'h233, 10'h022, 10'h133, 10'h244, 10'h144
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  task automatic doWrite(input logic [7:0] d);
    @(negedge wrClk); wrEn = 1; wrData = d;
    @(negedge wrClk); wrEn = 0;
  endtask

  task automatic doRead();
    @(negedge rdClk); rdEn = 1;
    @(negedge rdClk); rdEn = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge rdClk);
    repeat (4) @(negedge wrClk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nBad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge rdClk);
    wrRstN = 1; rdRstN = 1;
    settle();
    // R1 reset state
    chk("R1", "rdEmpty", rdEmpty, 1);
    chk("R1", "wrFull", wrFull, 0);
    chk("R1", "wrCount", wrCount, 0);
    chk("R1", "flags", {wrAck, wrOvf, rdValid, rdUnder}, 0);
    // R9 inverted polarity idles at 1
    chk("R9", "lo flags idle", {loAck, loOvf, loValid, loUnder}, 4'hF);

    // table walk: R2 order, R4 ack, R5 valid, R7 empty
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][9]) begin
        doWrite(VEC[i][7:0]);
        chk("R4", "wrAck after write", wrAck, 1);
        chk("R4", "wrOvf after write", wrOvf, 0);
        chk("R9", "lo ack active low", loAck, 0);
        @(negedge wrClk);
        chk("R4", "wrAck one cycle", wrAck, 0);
        settle();
        chk("R7", "empty cleared", rdEmpty, 0);
      end else begin
        doRead();
        chk("R5", "rdValid", rdValid, 1);
        chk("R2", "rdData order", rdData, VEC[i][7:0]);
        chk("R7", "empty after read", rdEmpty, VEC[i][8]);
        settle();
      end
    end

    // R6 underflow on empty
    doRead();
    chk("R6", "rdUnder", rdUnder, 1);
    chk("R6", "rdValid", rdValid, 0);
    chk("R6", "rdData held", rdData, 8'h44);
    chk("R9", "lo under active low", loUnder, 0);
    settle();

    // R8 count while filling, R3 full
    chk("R8", "count drained", wrCount, 0);
    for (int i = 0; i < DEPTH; i++) begin
      doWrite(8'hA0 + 8'(i));
      chk("R8", "count filling", wrCount, i + 1);
    end
    chk("R3", "wrFull", wrFull, 1);
    chk("R3", "count full", wrCount, DEPTH);

    // R10 overflow, R3 rejected
    doWrite(8'hEE);
    chk("R10", "wrOvf", wrOvf, 1);
    chk("R10", "wrAck", wrAck, 0);
    chk("R9", "lo ovf active low", loOvf, 0);
    chk("R3", "count after reject", wrCount, DEPTH);
    settle();

    // drain: R2 order, R3 rejected word absent
    for (int i = 0; i < DEPTH; i++) begin
      doRead();
      chk("R2", "drain data", rdData, 8'hA0 + i);
      chk("R5", "drain valid", rdValid, 1);
    end
    chk("R7", "empty after drain", rdEmpty, 1);
    doRead();
    chk("R3", "no rejected word", rdValid, 0);
    chk("R6", "under after drain", rdUnder, 1);
    chk("R6", "data held", rdData, 8'hAF);
    chk("R9", "lo valid active low", loValid, 1);
    settle();
    chk("R8", "count back to 0", wrCount, 0);
    chk("R3", "full cleared", wrFull, 0);

    // R6 pointer unchanged after underflow
    doWrite(8'h5A);
    settle();
    doRead();
    chk("R6", "next word after under", rdData, 8'h5A);
    chk("R5", "valid", rdValid, 1);

    summary();
    $finish;
  end
endmodule